// File: doc/BRIEF.md
# Multichannel DMA Control/Status Register File

This block is the software-visible register file of a small DMA controller with up to twelve channels. Through a 32-bit word-addressed write port and a combinational read port, software sets each channel's transfer mode and direction and enables its interrupt. Software also reads each channel's live engine state and acknowledges completion and error events. The channel engines take their mode and direction from dedicated outputs. They return a 2-bit state code and single-cycle done and error strobes.

Channels 0 to 7 are configured through the first control word and reported through the first status word. Channels 8 to 11 use the fourth control word and the third status word, at the same field positions relative to their index within the bank. Done and error events are latched into sticky flags that software clears by writing ones. The flags of enabled channels are ORed into one interrupt line.

Top module: `dma_csr_block`

## Requirements
- R1: A write to byte offset 0x00 stores, for each channel ch in 0..7, bits [4ch+1:4ch] as its mode (0 off, 1 descriptor chain, 2 single block, 3 stored as written) and bit 4ch+2 as its direction (1 memory-to-device). These drive ch_mode_o[2ch+1:2ch] and ch_dir_o[ch] from the next cycle and read back in place.
- R2: Channels 8..11 take the same 3-bit field from byte offset 0x0C at bits [4(ch-8)+2:4(ch-8)], with the same encodings and read-back.
- R3: Byte offset 0x08 holds the interrupt enables. Channel ch in 0..7 uses bit ch, and channel ch in 8..11 uses bit ch+8. All other bits of that word are ignored on write and read as zero.
- R4: Offset 0x10 bits [16+2ch+:2] show ch_state_i of channel ch (0..7) and offset 0x18 bits [16+2(ch-8)+:2] that of channels 8..11, live and read-only. Writes to these bits leave them unchanged.
- R5: A done strobe on channel ch sets its pending flag. The flag is bit ch of offset 0x10 for ch<8 and bit ch-8 of offset 0x18 for ch>=8, and it reads as set from the cycle after the strobe.
- R6: An error strobe on channel ch sets both its pending flag and its error flag. The error flag sits 8 bits above the pending flag in the same status word.
- R7: Writing 1 to a pending or error bit clears it, and writing 0 leaves it unchanged. A strobe arriving in the same cycle as the clear wins, and the flag stays set.
- R8: irq_o is high exactly while some channel has both its pending flag and its interrupt enable set. It follows the flags without further delay.
- R9: Offsets 0x04, 0x14 and 0x1C, and bit 3 of every channel nibble, ignore writes and read as zero.
- R10: After reset all modes are off, all directions 0, all enables 0, all pending and error flags 0, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ch_mode_o | output | 2*NUM_CH | Per-channel transfer mode |
| ch_dir_o | output | NUM_CH | Per-channel direction, 1 = memory-to-device |
| ch_state_i | input | 2*NUM_CH | Per-channel engine state code |
| ch_done_i | input | NUM_CH | Per-channel completion strobe |
| ch_err_i | input | NUM_CH | Per-channel error strobe |
| irq_o | output | 1 | Merged interrupt |

## Verification
A wrong bank or offset mapping shows up at once: the written nibble appears on the wrong channel's mode pins, or it reads back at the wrong position in the cycle after the write. A flag that is lost, stuck or cleared by a zero write shows up in the next status read and in irq_o within one cycle of the strobe or write. Because the bench sweeps every nibble value, every enable bit and every channel's done and error path, a wrong index usually shows on the first channel past the bank boundary.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int unsigned W_CTL0 = 0;
  localparam int unsigned W_CTL1 = 1;
  localparam int unsigned W_CTL2 = 2;
  localparam int unsigned W_CTL3 = 3;
  localparam int unsigned W_STS0 = 4;
  localparam int unsigned W_STS1 = 5;
  localparam int unsigned W_STS2 = 6;

  localparam int unsigned BANK_CH   = 8;   // channels per bank
  localparam int unsigned ERR_OFS   = 8;   // error flag above pending flag
  localparam int unsigned STATE_LSB = 16;  // state codes in upper half
  localparam int unsigned IE_HI_OFS = 16;  // upper-bank enables start here

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_CHAIN  = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_RSVD   = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    logic       dir;
    xfer_mode_e mode;
  } chan_cfg_t;
endpackage

// File: rtl/dma_csr_chan_cfg.sv
module dma_csr_chan_cfg
  import dmacsr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_cfg_i,
  input  chan_cfg_t cfg_i,
  input  logic      wr_ie_i,
  input  logic      ie_i,
  output chan_cfg_t cfg_o,
  output logic      ie_o
);
  chan_cfg_t cfg_q;
  logic      ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      if (wr_cfg_i) cfg_q <= cfg_i;
      if (wr_ie_i)  ie_q  <= ie_i;
    end
  end

  assign cfg_o = cfg_q;
  assign ie_o  = ie_q;

  a_r1_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg_i |=> $stable(cfg_o));
  a_r3_ie_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ie_i |=> $stable(ie_o));
endmodule

// File: rtl/dma_csr_evt_flags.sv
module dma_csr_evt_flags #(
  parameter int unsigned N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] err_i,
  input  logic [N-1:0] clr_pend_i,
  input  logic [N-1:0] clr_err_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] err_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, err_q;

  // new events take priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      err_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_pend_i) | done_i | err_i;
      err_q  <= (err_q & ~clr_err_i) | err_i;
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;
  assign irq_o  = |(pend_q & ie_i);

  a_r5_done_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> ((pend_o & $past(done_i)) == $past(done_i)));
  a_r6_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_i) |=> ((err_o & pend_o & $past(err_i)) == $past(err_i)));
  a_r7_pend_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_o) & ~pend_o & ~$past(clr_pend_i)) == '0));
  a_r7_err_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(err_o) & ~err_o & ~$past(clr_err_i)) == '0));
endmodule

// File: rtl/dma_csr_block.sv
module dma_csr_block
  import dmacsr_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [2*NUM_CH-1:0] ch_mode_o,
  output logic [NUM_CH-1:0]   ch_dir_o,
  input  logic [2*NUM_CH-1:0] ch_state_i,
  input  logic [NUM_CH-1:0]   ch_done_i,
  input  logic [NUM_CH-1:0]   ch_err_i,
  output logic                irq_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr_i[ADDR_W-1:2];

  logic wr_ctl0, wr_ctl2, wr_ctl3, wr_sts0, wr_sts2;
  assign wr_ctl0 = wr_en_i && (word == WORD_W'(W_CTL0));
  assign wr_ctl2 = wr_en_i && (word == WORD_W'(W_CTL2));
  assign wr_ctl3 = wr_en_i && (word == WORD_W'(W_CTL3));
  assign wr_sts0 = wr_en_i && (word == WORD_W'(W_STS0));
  assign wr_sts2 = wr_en_i && (word == WORD_W'(W_STS2));

  chan_cfg_t          cfg [NUM_CH];
  logic [NUM_CH-1:0]  ie, pend, err, clr_pend, clr_err;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam bit          HI     = (g >= BANK_CH);
    localparam int unsigned IDX    = HI ? g - BANK_CH : g;
    localparam int unsigned IE_BIT = HI ? IDX + IE_HI_OFS : IDX;

    logic wr_own_ctl, wr_own_sts;
    assign wr_own_ctl = HI ? wr_ctl3 : wr_ctl0;
    assign wr_own_sts = HI ? wr_sts2 : wr_sts0;

    dma_csr_chan_cfg u_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_cfg_i (wr_own_ctl),
      .cfg_i    (chan_cfg_t'(wdata_i[4*IDX +: 3])),
      .wr_ie_i  (wr_ctl2),
      .ie_i     (wdata_i[IE_BIT]),
      .cfg_o    (cfg[g]),
      .ie_o     (ie[g])
    );

    assign clr_pend[g]       = wr_own_sts && wdata_i[IDX];
    assign clr_err[g]        = wr_own_sts && wdata_i[IDX + ERR_OFS];
    assign ch_mode_o[2*g +: 2] = cfg[g].mode;
    assign ch_dir_o[g]       = cfg[g].dir;
  end

  dma_csr_evt_flags #(.N(NUM_CH)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (ch_done_i),
    .err_i      (ch_err_i),
    .clr_pend_i (clr_pend),
    .clr_err_i  (clr_err),
    .ie_i       (ie),
    .pend_o     (pend),
    .err_o      (err),
    .irq_o      (irq_o)
  );

  logic [31:0] ctl0_w, ctl2_w, ctl3_w, sts0_w, sts2_w;

  always_comb begin
    ctl0_w = '0;
    ctl2_w = '0;
    ctl3_w = '0;
    sts0_w = '0;
    sts2_w = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (c < BANK_CH) begin
        ctl0_w[4*(c%8) +: 3]             = cfg[c];
        ctl2_w[c%8]                      = ie[c];
        sts0_w[c%8]                      = pend[c];
        sts0_w[(c%8) + ERR_OFS]          = err[c];
        sts0_w[STATE_LSB + 2*(c%8) +: 2] = ch_state_i[2*c +: 2];
      end else begin
        ctl3_w[4*(c%8) +: 3]             = cfg[c];
        ctl2_w[(c%8) + IE_HI_OFS]        = ie[c];
        sts2_w[c%8]                      = pend[c];
        sts2_w[(c%8) + ERR_OFS]          = err[c];
        sts2_w[STATE_LSB + 2*(c%8) +: 2] = ch_state_i[2*c +: 2];
      end
    end
    unique case (word)
      WORD_W'(W_CTL0): rdata_o = ctl0_w;
      WORD_W'(W_CTL2): rdata_o = ctl2_w;
      WORD_W'(W_CTL3): rdata_o = ctl3_w;
      WORD_W'(W_STS0): rdata_o = sts0_w;
      WORD_W'(W_STS2): rdata_o = sts2_w;
      default:         rdata_o = '0;
    endcase
  end

  a_r8_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl2 && wdata_i == 32'h0) |=> !irq_o);
  a_r10_irq_quiet_without_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_o);
endmodule

// File: tb/dma_csr_block_bench.sv
module dma_csr_block_bench;
  localparam int NCH = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2*NCH-1:0] mode_o;
  logic [NCH-1:0]   dir_o;
  logic [2*NCH-1:0] state = '0;
  logic [NCH-1:0]   done = '0, errs = '0;
  logic        irq;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_csr_block u_dma_csr_block (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ch_mode_o(mode_o), .ch_dir_o(dir_o), .ch_state_i(state),
    .ch_done_i(done), .ch_err_i(errs), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] dm, input logic [NCH-1:0] em);
    @(negedge clk); done = dm; errs = em;
    @(negedge clk); done = '0; errs = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w0, w3, ex0, ex2;
    logic [2*NCH-1:0] em;
    logic [NCH-1:0]   ed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    for (int a = 0; a < 8; a++) begin
      rd(5'(a*4), d);
      check("R10 reset word", d, (a == 4 || a == 6) ? 32'h0 : 32'h0);
    end
    check("R10 reset mode", 32'(mode_o), 32'h0);
    check("R10 reset dir", 32'(dir_o), 32'h0);
    check("R10 reset irq", 32'(irq), 32'h0);

    // R1 R2 R9: every nibble value on all channels
    for (int v = 0; v < 16; v++) begin
      wr(5'h00, {8{4'(v)}});
      wr(5'h0C, {8{4'(v)}});
      rd(5'h00, d); check("R1 R9 ctl0 readback", d, {8{1'b0, 3'(v)}});
      rd(5'h0C, d); check("R2 R9 ctl3 readback", d, {16'h0, {4{1'b0, 3'(v)}}});
      check("R1 R2 mode pins", 32'(mode_o), 32'({NCH{2'(v)}}));
      check("R1 R2 dir pins", 32'(dir_o), 32'({NCH{v[2]}}));
    end
    // R1 R2: distinct nibble per channel
    for (int k = 1; k <= 8; k++) begin
      w0 = 32'h9E3779B9 * k;
      w3 = 32'h7F4A7C15 * k;
      wr(5'h00, w0);
      wr(5'h0C, w3);
      em = '0; ed = '0;
      for (int c = 0; c < NCH; c++) begin
        d = (c < 8) ? (w0 >> (4*c)) : (w3 >> (4*(c-8)));
        em[2*c +: 2] = d[1:0];
        ed[c] = d[2];
      end
      check("R1 R2 mixed mode", 32'(mode_o), 32'(em));
      check("R1 R2 mixed dir", 32'(dir_o), 32'(ed));
    end
    wr(5'h00, 0); wr(5'h0C, 0);

    // R3: walking enable bit
    for (int b = 0; b < 32; b++) begin
      wr(5'h08, 32'h1 << b);
      rd(5'h08, d);
      check("R3 enable position", d, (32'h1 << b) & 32'h000F_00FF);
    end

    // R4: state codes, uniform and mixed, read-only
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); state = {NCH{2'(s)}};
      rd(5'h10, d); check("R4 state sts0", d, {{8{2'(s)}}, 16'h0});
      rd(5'h18, d); check("R4 state sts2", d, {8'h0, {4{2'(s)}}, 16'h0});
    end
    @(negedge clk); state = 24'hE41BC6;
    wr(5'h10, 32'hFFFF_0000);
    wr(5'h18, 32'hFFFF_0000);
    rd(5'h10, d); check("R4 state after write sts0", d, {16'h1BC6, 16'h0});
    rd(5'h18, d); check("R4 state after write sts2", d, {8'h0, 8'hE4, 16'h0});
    @(negedge clk); state = '0;

    // R5 R6 R7 R8: per-channel done and error paths
    wr(5'h08, 32'h000F_00FF);
    for (int c = 0; c < NCH; c++) begin
      automatic logic [4:0] sa = (c < 8) ? 5'h10 : 5'h18;
      automatic int idx = c % 8;
      pulse(12'(1 << c), '0);
      rd(sa, d);  check("R5 pending set", d, 32'h1 << idx);
      check("R8 irq on pending", 32'(irq), 32'h1);
      wr(sa, 32'h1 << idx);
      rd(sa, d);  check("R7 pending cleared", d, 32'h0);
      check("R8 irq off", 32'(irq), 32'h0);
      pulse('0, 12'(1 << c));
      rd(sa, d);  check("R6 error sets both", d, (32'h101) << idx);
      wr(sa, (32'h101) << idx);
      rd(sa, d);  check("R7 both cleared", d, 32'h0);
    end

    // R7: zero writes keep flags, partial clear
    pulse('0, 12'h001);
    wr(5'h10, 32'h0);
    rd(5'h10, d); check("R7 zero write keeps", d, 32'h101);
    wr(5'h10, 32'h100);
    rd(5'h10, d); check("R7 clear error only", d, 32'h001);
    wr(5'h10, 32'h001);

    // R7: strobe wins over same-cycle clear
    pulse(12'h004, '0);
    @(negedge clk); done = 12'h004; addr = 5'h10; wdata = 32'h4; we = 1'b1;
    @(negedge clk); done = '0; we = 1'b0;
    rd(5'h10, d); check("R7 set wins pending", d, 32'h4);
    pulse('0, 12'h200);
    @(negedge clk); errs = 12'h200; addr = 5'h18; wdata = 32'h202; we = 1'b1;
    @(negedge clk); errs = '0; we = 1'b0;
    rd(5'h18, d); check("R7 set wins error", d, 32'h202);
    wr(5'h10, 32'hFFFF); wr(5'h18, 32'hFFFF);

    // R8: masking
    wr(5'h08, 32'h0);
    pulse(12'h402, '0);
    check("R8 masked pending", 32'(irq), 32'h0);
    wr(5'h08, 32'h0004_0000);
    check("R8 enable ch10", 32'(irq), 32'h1);
    wr(5'h18, 32'h4);
    check("R8 other channel masked", 32'(irq), 32'h0);
    wr(5'h08, 32'h2);
    check("R8 enable ch1", 32'(irq), 32'h1);
    wr(5'h10, 32'h2);

    // R9: reserved words
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); check("R9 ctl1 zero", d, 32'h0);
    wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, d); check("R9 sts1 zero", d, 32'h0);
    wr(5'h1C, 32'hFFFF_FFFF); rd(5'h1C, d); check("R9 gap zero", d, 32'h0);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d); check("R9 R3 ctl2 reserved", d, 32'h000F_00FF);
    check("R9 modes untouched", 32'(mode_o), 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule